// File: doc/BRIEF.md
# Pipeline Hazard Stall Unit

This block is the interlock controller for an in-order five-stage pipeline: fetch, decode, operand fetch, execute and write. The pipeline has no forwarding paths and a single memory port that both instruction fetch and data accesses use. Results land in the register file only at the end of the write stage. Operands are read while the instruction sits in decode. The unit therefore compares the source registers of the decode-stage instruction with the destinations of the instructions now in operand fetch and execute. On a match it freezes fetch and decode and sends an empty slot (valid=0) into operand fetch.

The unit also decides which requester owns the memory port in each cycle. A store issued by the write stage comes first, then an operand load from the operand-fetch stage, and instruction fetch gets the port only when neither data access wants it. If a load and a store collide, the operand-fetch stage holds along with the front of the pipe, and an empty slot goes into execute. All outputs are combinational functions of the current stage contents. The pipeline registers sample them at the next clock edge. The interface is a set of plain control signals with no valid/ready stream, so no back-pressure rules apply.

Top module: `hazard_interlock`

## Requirements
- R1: A valid decode instruction whose nonzero source equals the destination of a valid, register-writing instruction in operand fetch raises hold_front and bubble_opf, and drops fetch_en.
- R2: The same match against a valid, register-writing instruction in execute also raises hold_front and bubble_opf.
- R3: A dependent instruction directly behind its producer is held for exactly two cycles: the stall is present while the producer is in operand fetch and in execute, and gone once it reaches write.
- R4: Register 0 never causes a hazard, even when a producer names register 0 as its destination.
- R5: An invalid decode instruction, an invalid producer, or a producer that does not write a register causes no stall.
- R6: A match on either of the two source operands causes the stall.
- R7: mem_sel encodes the port owner as 0 = instruction fetch, 1 = operand load (opf_load), 2 = store (wrb_store). A store takes priority over a load, and a load takes priority over fetch.
- R8: fetch_en is high only when mem_sel is 0 and hold_front is low.
- R9: When a load and a store are requested in the same cycle, hold_opf, hold_front and bubble_exe are high and bubble_opf is low, whether or not a register hazard is also present.
- R10: With no hazard and no data access, fetch_en is high, mem_sel is 0, and every hold and bubble output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the embedded checks) |
| rst_n | input | 1 | Active-low reset (disables the embedded checks) |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_src | input | NUM_SRC*REG_W | Source register numbers of the decode instruction, operand 0 in the low bits |
| opf_valid | input | 1 | Operand-fetch stage holds an instruction |
| opf_dest | input | REG_W | Destination register of the operand-fetch instruction |
| opf_wr | input | 1 | Operand-fetch instruction writes a register |
| opf_load | input | 1 | Operand-fetch instruction reads an operand from memory |
| exe_valid | input | 1 | Execute stage holds an instruction |
| exe_dest | input | REG_W | Destination register of the execute instruction |
| exe_wr | input | 1 | Execute instruction writes a register |
| wrb_valid | input | 1 | Write stage holds an instruction |
| wrb_store | input | 1 | Write-stage instruction stores its result to memory |
| fetch_en | output | 1 | Start an instruction fetch this cycle |
| hold_front | output | 1 | Freeze the fetch and decode registers |
| hold_opf | output | 1 | Freeze the operand-fetch register |
| bubble_opf | output | 1 | Load an empty slot into operand fetch |
| bubble_exe | output | 1 | Load an empty slot into execute |
| mem_sel | output | 2 | Memory port owner code |

## Verification
The embedded checks watch several relations on every cycle. Fetch never starts while a data access owns the port. An operand-fetch hold always comes with a front hold. At most one bubble is inserted per cycle. An empty decode stage or an all-zero source pair never produces a bubble. The bench's scenarios are needed for the rest: the actual comparison outcomes per stage and per operand, the store-over-load-over-fetch priority codes, and the two-cycle stall sequence as a producer moves from operand fetch through execute to write.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int REG_W    = 5;
  localparam int NUM_SRC  = 2;
  localparam int NUM_PROD = 2;  // operand fetch and execute

  typedef enum logic [1:0] {
    PORT_FETCH  = 2'd0,
    PORT_OPREAD = 2'd1,
    PORT_STORE  = 2'd2
  } port_sel_e;
endpackage

// File: rtl/raw_detect.sv
module raw_detect #(
  parameter int REG_W    = 5,
  parameter int NUM_SRC  = 2,
  parameter int NUM_PROD = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              dec_valid,
  input  logic [NUM_SRC-1:0][REG_W-1:0]     dec_src,
  input  logic [NUM_PROD-1:0]               prod_valid,
  input  logic [NUM_PROD-1:0]               prod_wr,
  input  logic [NUM_PROD-1:0][REG_W-1:0]    prod_dest,
  output logic                              raw_hit
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [NUM_SRC-1:0][NUM_PROD-1:0] pair_hit;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
      assign pair_hit[s][p] = prod_valid[p] && prod_wr[p] &&
                              (dec_src[s] != ZERO_REG) &&
                              (dec_src[s] == prod_dest[p]);
    end
  end

  assign raw_hit = dec_valid && (|pair_hit);

  // R4: all-zero sources can never match
  a_r4_zero_src_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_src == '0) |-> !raw_hit);
endmodule

// File: rtl/port_arbiter.sv
module port_arbiter
  import hazard_pkg::*;
(
  input  logic      load_req,
  input  logic      store_req,
  output port_sel_e sel,
  output logic      data_busy,
  output logic      conflict
);
  always_comb begin
    if (store_req)     sel = PORT_STORE;
    else if (load_req) sel = PORT_OPREAD;
    else               sel = PORT_FETCH;
  end

  assign data_busy = load_req || store_req;
  assign conflict  = load_req && store_req;
endmodule

// File: rtl/stall_ctrl.sv
module stall_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_hit,
  input  logic data_busy,
  input  logic conflict,
  output logic fetch_en,
  output logic hold_front,
  output logic hold_opf,
  output logic bubble_opf,
  output logic bubble_exe
);
  assign hold_opf   = conflict;
  assign hold_front = raw_hit || conflict;
  assign bubble_exe = conflict;
  assign bubble_opf = raw_hit && !conflict;
  assign fetch_en   = !hold_front && !data_busy;

  // R9: an operand-fetch hold always freezes the front as well
  a_r9_hold_nested: assert property (@(posedge clk) disable iff (!rst_n)
    hold_opf |-> hold_front);

  // R9: never two bubbles in one cycle
  a_r9_single_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    !(bubble_opf && bubble_exe));
endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
  import hazard_pkg::*;
#(
  parameter int REG_W   = hazard_pkg::REG_W,
  parameter int NUM_SRC = hazard_pkg::NUM_SRC
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dec_valid,
  input  logic [NUM_SRC-1:0][REG_W-1:0] dec_src,
  input  logic                          opf_valid,
  input  logic [REG_W-1:0]              opf_dest,
  input  logic                          opf_wr,
  input  logic                          opf_load,
  input  logic                          exe_valid,
  input  logic [REG_W-1:0]              exe_dest,
  input  logic                          exe_wr,
  input  logic                          wrb_valid,
  input  logic                          wrb_store,
  output logic                          fetch_en,
  output logic                          hold_front,
  output logic                          hold_opf,
  output logic                          bubble_opf,
  output logic                          bubble_exe,
  output logic [1:0]                    mem_sel
);
  localparam int NPROD = hazard_pkg::NUM_PROD;

  logic [NPROD-1:0]            p_valid;
  logic [NPROD-1:0]            p_wr;
  logic [NPROD-1:0][REG_W-1:0] p_dest;
  logic                        raw_hit;
  logic                        data_busy;
  logic                        conflict;
  port_sel_e                   sel;

  assign p_valid = {exe_valid, opf_valid};
  assign p_wr    = {exe_wr,    opf_wr};
  assign p_dest  = {exe_dest,  opf_dest};

  raw_detect #(.REG_W(REG_W), .NUM_SRC(NUM_SRC), .NUM_PROD(NPROD)) u_raw (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_valid  (dec_valid),
    .dec_src    (dec_src),
    .prod_valid (p_valid),
    .prod_wr    (p_wr),
    .prod_dest  (p_dest),
    .raw_hit    (raw_hit)
  );

  port_arbiter u_arb (
    .load_req  (opf_valid && opf_load),
    .store_req (wrb_valid && wrb_store),
    .sel       (sel),
    .data_busy (data_busy),
    .conflict  (conflict)
  );

  stall_ctrl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_hit    (raw_hit),
    .data_busy  (data_busy),
    .conflict   (conflict),
    .fetch_en   (fetch_en),
    .hold_front (hold_front),
    .hold_opf   (hold_opf),
    .bubble_opf (bubble_opf),
    .bubble_exe (bubble_exe)
  );

  assign mem_sel = sel;

  // R8: fetch only starts when the arbiter leaves the port to fetch
  a_r8_fetch_port_free: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |-> (mem_sel == PORT_FETCH));

  // R5: an empty decode stage never pushes a bubble into operand fetch
  a_r5_no_dec_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !bubble_opf);

  // R7: the port code is always one of the three defined owners
  a_r7_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel != 2'd3);
endmodule

// File: tb/hazard_interlock_tb_top.sv
module hazard_interlock_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic            dec_valid = 0;
  logic [1:0][4:0] dec_src = '0;
  logic            opf_valid = 0, opf_wr = 0, opf_load = 0;
  logic [4:0]      opf_dest = '0;
  logic            exe_valid = 0, exe_wr = 0;
  logic [4:0]      exe_dest = '0;
  logic            wrb_valid = 0, wrb_store = 0;
  logic            fetch_en, hold_front, hold_opf, bubble_opf, bubble_exe;
  logic [1:0]      mem_sel;

  hazard_interlock dut_i (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dec_valid), .dec_src(dec_src),
    .opf_valid(opf_valid), .opf_dest(opf_dest), .opf_wr(opf_wr), .opf_load(opf_load),
    .exe_valid(exe_valid), .exe_dest(exe_dest), .exe_wr(exe_wr),
    .wrb_valid(wrb_valid), .wrb_store(wrb_store),
    .fetch_en(fetch_en), .hold_front(hold_front), .hold_opf(hold_opf),
    .bubble_opf(bubble_opf), .bubble_exe(bubble_exe), .mem_sel(mem_sel)
  );

  typedef struct packed {
    logic       dv;
    logic [4:0] sa;
    logic [4:0] sb;
    logic       ov;
    logic [4:0] od;
    logic       ow;
    logic       ol;
    logic       ev;
    logic [4:0] ed;
    logic       ew;
    logic       wv;
    logic       ws;
    logic       fe;
    logic       hf;
    logic       ho;
    logic       bo;
    logic       be;
    logic [1:0] ms;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 15;
  // fields: dv sa sb | ov od ow ol | ev ed ew | wv ws || fe hf ho bo be ms | req
  localparam vec_t VECS [NV] = '{
    '{1, 1, 2,  1, 3, 1, 0,  1, 4, 1,  1, 0,  1, 0, 0, 0, 0, 0, 10}, // R10 idle
    '{1, 3, 2,  1, 3, 1, 0,  0, 0, 0,  0, 0,  0, 1, 0, 1, 0, 0,  1}, // R1 opf match
    '{1, 1, 3,  0, 0, 0, 0,  1, 3, 1,  0, 0,  0, 1, 0, 1, 0, 0,  2}, // R2 exe match
    '{1, 0, 0,  1, 0, 1, 0,  1, 0, 1,  0, 0,  1, 0, 0, 0, 0, 0,  4}, // R4 reg 0
    '{0, 3, 3,  1, 3, 1, 0,  1, 3, 1,  0, 0,  1, 0, 0, 0, 0, 0,  5}, // R5 dec empty
    '{1, 3, 3,  1, 3, 0, 0,  1, 3, 0,  0, 0,  1, 0, 0, 0, 0, 0,  5}, // R5 no write
    '{1, 3, 3,  0, 3, 1, 0,  0, 3, 1,  0, 0,  1, 0, 0, 0, 0, 0,  5}, // R5 prod empty
    '{1, 9, 6,  1, 6, 1, 0,  0, 0, 0,  0, 0,  0, 1, 0, 1, 0, 0,  6}, // R6 source b
    '{1, 1, 2,  1, 5, 1, 1,  0, 0, 0,  0, 0,  0, 0, 0, 0, 0, 1,  7}, // R7 load
    '{1, 1, 2,  0, 0, 0, 0,  0, 0, 0,  1, 1,  0, 0, 0, 0, 0, 2,  7}, // R7 store
    '{1, 1, 2,  1, 5, 1, 1,  0, 0, 0,  1, 1,  0, 1, 1, 0, 1, 2,  9}, // R9 collide
    '{1, 5, 2,  1, 5, 1, 1,  0, 0, 0,  1, 1,  0, 1, 1, 0, 1, 2,  9}, // R9 collide+raw
    '{1, 7, 1,  1, 7, 1, 0,  0, 0, 0,  0, 0,  0, 1, 0, 1, 0, 0,  3}, // R3 cycle 1
    '{1, 7, 1,  0, 0, 0, 0,  1, 7, 1,  0, 0,  0, 1, 0, 1, 0, 0,  3}, // R3 cycle 2
    '{1, 7, 1,  0, 0, 0, 0,  0, 0, 0,  1, 0,  1, 0, 0, 0, 0, 0,  3}  // R3 cycle 3 free
  };

  int errors = 0;
  int checks = 0;

  task automatic chk(input string what, input int req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_outs(input string tag, input int req, input logic fe, input logic hf,
                            input logic ho, input logic bo, input logic be, input logic [1:0] ms);
    chk({tag, " fetch_en"},   req, fetch_en,   fe);
    chk({tag, " hold_front"}, req, hold_front, hf);
    chk({tag, " hold_opf"},   req, hold_opf,   ho);
    chk({tag, " bubble_opf"}, req, bubble_opf, bo);
    chk({tag, " bubble_exe"}, req, bubble_exe, be);
    chk({tag, " mem_sel"},    req, mem_sel,    ms);
  endtask

  task automatic drive(input vec_t v);
    dec_valid = v.dv; dec_src = {v.sb, v.sa};
    opf_valid = v.ov; opf_dest = v.od; opf_wr = v.ow; opf_load = v.ol;
    exe_valid = v.ev; exe_dest = v.ed; exe_wr = v.ew;
    wrb_valid = v.wv; wrb_store = v.ws;
  endtask

  initial begin
    // reset state, R10: all stages empty
    @(negedge clk);
    #5 check_outs("reset", 10, 1, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #5 check_outs($sformatf("vec%0d", i), int'(VECS[i].req),
                    VECS[i].fe, VECS[i].hf, VECS[i].ho, VECS[i].bo, VECS[i].be, VECS[i].ms);
    end

    // R8: write stage busy without a store leaves the port to fetch
    @(negedge clk);
    drive('{1, 1, 2, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 8});
    #5 check_outs("r8_wrb_nostore", 8, 1, 0, 0, 0, 0, 0);

    // R7: a load flag on an empty operand-fetch stage claims nothing
    @(negedge clk);
    drive('{0, 0, 0, 0, 4, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 7});
    #5 check_outs("r7_load_invalid", 7, 1, 0, 0, 0, 0, 0);

    // R2 with R6: execute match on source b while a load holds the port
    @(negedge clk);
    drive('{1, 2, 11, 1, 4, 1, 1, 1, 11, 1, 0, 0, 0, 0, 0, 0, 0, 0, 2});
    #5 check_outs("r2_exe_b_load", 2, 0, 1, 0, 1, 0, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule